// File: doc/BRIEF.md
# Two-Level Round-Robin Switch Allocator

This block decides, every cycle, which input virtual channel may send a flit through each output of a high-radix crossbar. Each input carries several virtual channels (VCs). Every VC has a request bit and a binary field that names the output it wants. The block settles the contention in three arbitration steps. First, each input picks one of its bidding VCs. Next, for every output, a local arbiter picks one input from a small group of neighbouring inputs. Last, a global arbiter per output picks one of the group winners. The winning input VC then receives a one-cycle grant.

The steps are pipelined, and an extra register stage models the long wire run from the input side to the output side, so a request is answered a fixed four cycles after it is sampled. Each arbiter holds its own rotating priority. A priority moves only when the choice it made turns into a final grant, so a loser at a later step keeps its place at an earlier one.

The request/grant pair follows a valid/ready style with a fixed delay. A VC holds its request bit high for as long as it has flits to send. Each grant removes exactly one flit. A grant answers the bid sampled four edges earlier, and the requester must still have that flit available. Dropping the request stops new bids only.

Top module: `hla_switch_alloc`

## Requirements
- R1: A bid sampled on rising edge n that wins every step drives its grant bit high for exactly the one cycle that follows edge n+3. No other grant bit is raised for it.
- R2: With K inputs and V VCs, VC c of input i uses request bit i*V+c and grant bit i*V+c. Its destination is the binary output number in `vc_dst[(i*V+c)*OW +: OW]`, where OW = clog2(K).
- R3: Each input chooses among its bidding VCs in round-robin order. Its pointer starts at VC 0 and moves to just past a VC on the edge after that VC's grant is visible. A VC that keeps bidding while others also bid is therefore granted within a bounded window.
- R4: Inputs form groups of M consecutive inputs (group g is inputs g*M to g*M+M-1). For each output and each group, a round-robin pointer chooses one input. This pointer moves past its registered choice only on the edge where the global step picks that group.
- R5: For each output, the global step chooses among the K/M group winners in round-robin order. Its pointer moves past the granted group.
- R6: An output with at least one pending group winner issues exactly one grant in the next cycle. No input ever receives more than one grant bit in a cycle.
- R7: An output with no requests issues no grant and leaves all of its pointers unchanged. When every request is low, the grant vector is zero from the fourth edge onward.
- R8: While `rst_n` is low, all grant bits are zero, and all pointers return to index 0.
- R9: A VC that holds its request high alone on an otherwise idle output is granted on every cycle. The grant sequence is its request sequence delayed by four cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vc_req | input | K*V | Per-VC request bit, index i*V+c |
| vc_dst | input | K*V*OW | Per-VC binary output number, field i*V+c |
| vc_gnt | output | K*V | One-cycle grant pulse, index i*V+c |

## Verification
The hardest situation to reach is a loss at the local or global step while the same input keeps re-bidding. In that case the pointers at the three steps move on different edges, and a wrong update edge changes the grant order only many cycles later. The stimulus creates this case in several ways: it puts all four VCs of one input on different outputs, it packs a whole group onto one output, it puts one member of every group onto a shared output, and it sends all inputs to a single output. It then runs a long random phase with destinations crowded onto a few outputs. Throughout, a cycle-accurate behavioural model predicts every grant bit on every cycle.

// File: rtl/hla_pkg.sv
package hla_pkg;
  // Index width for a selector over n items; at least one bit.
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hla_rr_arb.sv
module hla_rr_arb #(
  parameter int N = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N-1:0]                 req,
  input  logic                         upd,
  input  logic [hla_pkg::idx_w(N)-1:0] upd_idx,
  output logic                         any,
  output logic [hla_pkg::idx_w(N)-1:0] win
);
  localparam int IW = hla_pkg::idx_w(N);

  logic [IW-1:0] ptr;

  // Scan from the pointer upward with wrap; the nearest requester wins.
  always_comb begin
    logic [IW:0]   s;
    logic [IW-1:0] c;
    any = 1'b0;
    win = '0;
    s   = '0;
    c   = '0;
    for (int j = N - 1; j >= 0; j--) begin
      s = {1'b0, ptr} + (IW+1)'(j);
      if (s >= (IW+1)'(N)) s = s - (IW+1)'(N);
      c = s[IW-1:0];
      if (req[c]) begin
        any = 1'b1;
        win = c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (upd) ptr <= (int'(upd_idx) == N - 1) ? '0 : upd_idx + IW'(1);
  end

  // R3 R4 R5: the requester sitting at the pointer always has top priority
  assert_ptr_holder_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any && req[ptr]) |-> (win == ptr));
endmodule

// File: rtl/hla_in_stage.sv
module hla_in_stage #(
  parameter int V  = 4,
  parameter int OW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [V-1:0]                 bid,
  input  logic [V*OW-1:0]              dst_flat,
  input  logic                         hit,
  input  logic [hla_pkg::idx_w(V)-1:0] hit_vc,
  output logic                         o_vld,
  output logic [hla_pkg::idx_w(V)-1:0] o_vc,
  output logic [OW-1:0]                o_dst
);
  localparam int VW = hla_pkg::idx_w(V);

  logic [OW-1:0] dst_a [V];
  logic          any;
  logic [VW-1:0] win;

  for (genvar c = 0; c < V; c++) begin : g_dst
    assign dst_a[c] = dst_flat[c*OW +: OW];
  end

  hla_rr_arb #(.N(V)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(bid),
    .upd(hit), .upd_idx(hit_vc),
    .any(any), .win(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld <= 1'b0;
      o_vc  <= '0;
      o_dst <= '0;
    end else begin
      o_vld <= any;
      o_vc  <= win;
      o_dst <= dst_a[win];
    end
  end

  // R3: a registered pick always names a VC that was bidding on that edge
  assert_pick_was_bid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (|($past(bid) & (V'(1) << o_vc))));
endmodule

// File: rtl/hla_out_port.sv
module hla_out_port #(
  parameter int K      = 16,
  parameter int M      = 4,
  parameter int V      = 4,
  parameter int OUT_ID = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [K-1:0]                 in_vld,
  input  logic [K*hla_pkg::idx_w(K)-1:0] in_dst,
  input  logic [K*hla_pkg::idx_w(V)-1:0] in_vc,
  output logic                         gnt_vld,
  output logic [hla_pkg::idx_w(K)-1:0] gnt_src,
  output logic [hla_pkg::idx_w(V)-1:0] gnt_vc
);
  localparam int G  = K / M;
  localparam int OW = hla_pkg::idx_w(K);
  localparam int VW = hla_pkg::idx_w(V);
  localparam int MW = hla_pkg::idx_w(M);
  localparam int GW = hla_pkg::idx_w(G);

  logic [G-1:0]  l_vld;
  logic [MW-1:0] l_idx [G];
  logic [VW-1:0] l_vc  [G];
  logic          g_any;
  logic [GW-1:0] g_win;

  // Local step: one arbiter per group, fed by decoded output codes
  for (genvar g = 0; g < G; g++) begin : g_loc
    logic [M-1:0]  lreq;
    logic [VW-1:0] vc_a [M];
    logic          a_any;
    logic [MW-1:0] a_win;
    logic          r_vld;
    logic [MW-1:0] r_idx;
    logic [VW-1:0] r_vc;

    for (genvar j = 0; j < M; j++) begin : g_mem
      assign lreq[j] = in_vld[g*M+j] && (in_dst[(g*M+j)*OW +: OW] == OW'(OUT_ID));
      assign vc_a[j] = in_vc[(g*M+j)*VW +: VW];
    end

    hla_rr_arb #(.N(M)) u_loc (
      .clk(clk), .rst_n(rst_n), .req(lreq),
      .upd(g_any && (g_win == GW'(g))), .upd_idx(r_idx),
      .any(a_any), .win(a_win)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_vld <= 1'b0;
        r_idx <= '0;
        r_vc  <= '0;
      end else begin
        r_vld <= a_any;
        r_idx <= a_win;
        r_vc  <= vc_a[a_win];
      end
    end

    assign l_vld[g] = r_vld;
    assign l_idx[g] = r_idx;
    assign l_vc[g]  = r_vc;
  end

  // Global step across group winners
  hla_rr_arb #(.N(G)) u_glb (
    .clk(clk), .rst_n(rst_n), .req(l_vld),
    .upd(g_any), .upd_idx(g_win),
    .any(g_any), .win(g_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_vld <= 1'b0;
      gnt_src <= '0;
      gnt_vc  <= '0;
    end else begin
      gnt_vld <= g_any;
      gnt_src <= OW'(int'(g_win) * M + int'(l_idx[g_win]));
      gnt_vc  <= l_vc[g_win];
    end
  end

  // R6: any pending group winner turns into a grant on the next cycle
  assert_pending_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|l_vld) |=> gnt_vld);
  // R7: with nothing pending at this output, no grant follows
  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|l_vld) |=> !gnt_vld);
endmodule

// File: rtl/hla_switch_alloc.sv
module hla_switch_alloc #(
  parameter int K = 16,
  parameter int V = 4,
  parameter int M = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [K*V-1:0]                  vc_req,
  input  logic [K*V*hla_pkg::idx_w(K)-1:0] vc_dst,
  output logic [K*V-1:0]                  vc_gnt
);
  localparam int OW = hla_pkg::idx_w(K);
  localparam int VW = hla_pkg::idx_w(V);

  logic [K-1:0]    s1_vld, s2_vld;
  logic [K*VW-1:0] s1_vc,  s2_vc;
  logic [K*OW-1:0] s1_dst, s2_dst;
  logic [K-1:0]    p_vld;
  logic [K*OW-1:0] p_src;
  logic [K*VW-1:0] p_vc;
  logic [K-1:0]    in_hit;
  logic [K*VW-1:0] in_vc;

  // Step 1: per-input VC choice
  for (genvar i = 0; i < K; i++) begin : g_in
    hla_in_stage #(.V(V), .OW(OW)) u_in (
      .clk(clk), .rst_n(rst_n),
      .bid(vc_req[i*V +: V]),
      .dst_flat(vc_dst[i*V*OW +: V*OW]),
      .hit(in_hit[i]), .hit_vc(in_vc[i*VW +: VW]),
      .o_vld(s1_vld[i]), .o_vc(s1_vc[i*VW +: VW]), .o_dst(s1_dst[i*OW +: OW])
    );
  end

  // Wire stage: request lines crossing to the output side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= '0;
      s2_vc  <= '0;
      s2_dst <= '0;
    end else begin
      s2_vld <= s1_vld;
      s2_vc  <= s1_vc;
      s2_dst <= s1_dst;
    end
  end

  // Steps 2 and 3: one two-level arbiter per output
  for (genvar o = 0; o < K; o++) begin : g_out
    hla_out_port #(.K(K), .M(M), .V(V), .OUT_ID(o)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_vld(s2_vld), .in_dst(s2_dst), .in_vc(s2_vc),
      .gnt_vld(p_vld[o]), .gnt_src(p_src[o*OW +: OW]), .gnt_vc(p_vc[o*VW +: VW])
    );
  end

  // Grant return: route each output's winner back to its input VC
  for (genvar i = 0; i < K; i++) begin : g_ret
    for (genvar c = 0; c < V; c++) begin : g_bit
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int o = 0; o < K; o++)
          if (p_vld[o] && p_src[o*OW +: OW] == OW'(i) && p_vc[o*VW +: VW] == VW'(c))
            hit = 1'b1;
      end
      assign vc_gnt[i*V+c] = hit;
    end

    always_comb begin
      in_hit[i]            = 1'b0;
      in_vc[i*VW +: VW]    = '0;
      for (int c = 0; c < V; c++)
        if (vc_gnt[i*V+c]) begin
          in_hit[i]         = 1'b1;
          in_vc[i*VW +: VW] = VW'(c);
        end
    end

    // R6: one input never collects two grants at once
    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vc_gnt[i*V +: V]));
  end

  // R1 R9: every grant answers a bid sampled four edges earlier
  for (genvar b = 0; b < K*V; b++) begin : g_lat
    assert_grant_had_bid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      vc_gnt[b] |-> $past(vc_req[b], 4));
  end
endmodule

// File: tb/sim_hla_switch_alloc.sv
`timescale 1ns/1ps
module sim_hla_switch_alloc;
  localparam int K  = 16;
  localparam int V  = 4;
  localparam int M  = 4;
  localparam int G  = K / M;
  localparam int OW = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [K*V-1:0]   vc_req;
  logic [K*V*OW-1:0] vc_dst;
  logic [K*V-1:0]   vc_gnt;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur   = "R8";
  logic [31:0] seed = 32'h1234_5678;

  hla_switch_alloc #(.K(K), .V(V), .M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .vc_req(vc_req), .vc_dst(vc_dst), .vc_gnt(vc_gnt)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int ip [K];
  bit m1v [K]; int m1c [K]; int m1d [K];
  bit m2v [K]; int m2c [K]; int m2d [K];
  bit m3v [K][G]; int m3i [K][G]; int m3c [K][G];
  bit n3v [K][G]; int n3i [K][G]; int n3c [K][G];
  bit n1v [K]; int n1c [K]; int n1d [K];
  int lp [K][G];
  int gp [K];
  logic [K*V-1:0] expg = '0;
  logic [K*V-1:0] ng;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < K; a++) begin
        ip[a] = 0; gp[a] = 0; m1v[a] = 0; m2v[a] = 0;
        for (int g = 0; g < G; g++) begin lp[a][g] = 0; m3v[a][g] = 0; end
      end
      expg = '0;
    end else begin
      // group step on wire-stage bids, old pointers
      for (int o = 0; o < K; o++)
        for (int g = 0; g < G; g++) begin
          n3v[o][g] = 0; n3i[o][g] = 0; n3c[o][g] = 0;
          for (int j = 0; j < M; j++) begin
            int x; int src;
            x = (lp[o][g] + j) % M; src = g*M + x;
            if (!n3v[o][g] && m2v[src] && m2d[src] == o) begin
              n3v[o][g] = 1; n3i[o][g] = x; n3c[o][g] = m2c[src];
            end
          end
        end
      // global step on registered group winners
      ng = '0;
      for (int o = 0; o < K; o++) begin
        bit f; f = 0;
        for (int j = 0; j < G; j++) begin
          int g; g = (gp[o] + j) % G;
          if (!f && m3v[o][g]) begin
            f = 1;
            ng[(g*M + m3i[o][g])*V + m3c[o][g]] = 1'b1;
            lp[o][g] = (m3i[o][g] + 1) % M;
            gp[o] = (g + 1) % G;
          end
        end
      end
      // input step, old pointer
      for (int a = 0; a < K; a++) begin
        n1v[a] = 0; n1c[a] = 0; n1d[a] = 0;
        for (int j = 0; j < V; j++) begin
          int c; c = (ip[a] + j) % V;
          if (!n1v[a] && vc_req[a*V+c]) begin
            n1v[a] = 1; n1c[a] = c; n1d[a] = int'(vc_dst[(a*V+c)*OW +: OW]);
          end
        end
      end
      // input pointers follow the grant now visible
      for (int a = 0; a < K; a++)
        for (int c = 0; c < V; c++)
          if (expg[a*V+c]) ip[a] = (c + 1) % V;
      m3v = n3v; m3i = n3i; m3c = n3c;
      m2v = m1v; m2c = m1c; m2d = m1d;
      m1v = n1v; m1c = n1c; m1d = n1d;
      expg = ng;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (vc_gnt !== expg) begin
        n_bad++;
        $display("FAIL %s model compare: actual %h expected %h", cur, vc_gnt, expg);
      end
    end
  end

  task automatic chk(string rq, string what, longint act, longint exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp_v);
    end
  endtask

  task automatic set_dst(int inp, int vc, int dst);
    vc_dst[(inp*V+vc)*OW +: OW] = OW'(dst);
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic idle(int n);
    vc_req = '0;
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt [V];
    int tot;
    rst_n  = 1'b0;
    vc_req = '0;
    vc_dst = '0;

    // R8: reset state
    cur = "R8";
    repeat (3) @(negedge clk);
    chk("R8", "grants in reset", longint'(vc_gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: single bid, exact latency and bit position
    cur = "R1";
    set_dst(5, 2, 9);
    vc_req[5*V+2] = 1'b1;
    @(negedge clk);
    vc_req = '0;
    chk("R1", "after edge 1", longint'(vc_gnt), 0);
    @(negedge clk); chk("R1", "after edge 2", longint'(vc_gnt), 0);
    @(negedge clk); chk("R1", "after edge 3", longint'(vc_gnt), 0);
    @(negedge clk); chk("R2", "grant bit 22", longint'(vc_gnt), longint'(64'd1 << 22));
    @(negedge clk); chk("R1", "pulse width", longint'(vc_gnt), 0);
    idle(4);

    // R3: all VCs of input 0 bid for different outputs
    cur = "R3";
    for (int c = 0; c < V; c++) begin set_dst(0, c, c + 1); vc_req[c] = 1'b1; cnt[c] = 0; end
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      for (int c = 0; c < V; c++) if (vc_gnt[c]) cnt[c]++;
    end
    for (int c = 0; c < V; c++) chk("R3", $sformatf("VC%0d served", c), longint'(cnt[c] > 0), 1);
    idle(6);

    // R4: one whole group contends for output 7
    cur = "R4";
    for (int a = 0; a < M; a++) begin set_dst(a, 0, 7); vc_req[a*V] = 1'b1; cnt[a] = 0; end
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      for (int a = 0; a < M; a++) if (vc_gnt[a*V]) cnt[a]++;
    end
    for (int a = 0; a < M; a++) chk("R4", $sformatf("input %0d share", a), longint'(cnt[a] >= 8), 1);
    idle(6);

    // R5: one member of every group contends for output 3
    cur = "R5";
    for (int g = 0; g < G; g++) begin set_dst(g*M, 1, 3); vc_req[g*M*V+1] = 1'b1; cnt[g] = 0; end
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      for (int g = 0; g < G; g++) if (vc_gnt[g*M*V+1]) cnt[g]++;
    end
    for (int g = 0; g < G; g++) chk("R5", $sformatf("group %0d share", g), longint'(cnt[g] >= 8), 1);
    idle(6);

    // R9: held lone request granted every cycle, delayed by four
    cur = "R9";
    set_dst(3, 1, 0);
    vc_req[3*V+1] = 1'b1;
    tot = 0;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      if (t == 9) vc_req = '0;
      if (vc_gnt[3*V+1]) tot++;
    end
    chk("R9", "grants for 10 held cycles", tot, 10);

    // R7: no requests, no grants
    cur = "R7";
    idle(4);
    tot = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); tot += $countones(vc_gnt); end
    chk("R7", "grants while idle", tot, 0);

    // R6: all inputs on output 11, one grant every cycle
    cur = "R6";
    for (int a = 0; a < K; a++) begin set_dst(a, 0, 11); vc_req[a*V] = 1'b1; end
    repeat (4) @(negedge clk);
    tot = 0;
    for (int t = 0; t < 32; t++) begin @(negedge clk); tot += $countones(vc_gnt); end
    chk("R6", "grants in 32 busy cycles", tot, 32);
    idle(6);

    // R6 / R7: random traffic, crowded then spread destinations
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      cur = (t < 1500) ? "R6" : "R7";
      vc_req = {rnd() & rnd(), rnd() & rnd()};
      for (int b = 0; b < K*V; b++)
        vc_dst[b*OW +: OW] = (t < 1500) ? OW'(rnd() % 4) : OW'(rnd() >> 7);
    end
    idle(8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule